// File: doc/BRIEF.md
# Multicycle Datapath for a Small Load/Store Integer Subset

This block is the 32-bit datapath of a processor that spreads each instruction over several clock cycles. It supports word loads and stores, register-to-register add, subtract, and, or and set-less-than, a branch on equality and an absolute jump. One memory array serves both instruction fetch and data access. One ALU does the PC increment, the branch-target sum and the data operations. Holding registers latch results between cycles: the instruction register, the memory data register, the two operand registers and the ALU output register.

The datapath makes no decisions of its own. An external controller sequences every cycle by driving the multiplexer selects and write enables. The datapath returns the opcode, the function field, the ALU zero flag and the signed-overflow flag to that controller. The current PC and the latched ALU result also leave the block, so a system can follow execution.

The memory is a small behavioural array inside the block, so the block can be tested with no outside parts. Instructions that wait on memory are not covered. Each memory access completes in the cycle it is requested.

Top module: `mcdp_core`

## Requirements
- R1: While rst_n is low, the PC, the instruction register, the memory data register, both operand registers, the ALU output register and all register-file entries are cleared. pc_o, alu_out_o, opcode and funct therefore read 0.
- R2: On a clock edge with ir_write high, the instruction register loads the memory read data. With ir_write low it holds its value. opcode is IR[31:26] and funct is IR[5:0].
- R3: The memory word address is PC[9:2] when i_or_d is 0 and ALUOut[9:2] when i_or_d is 1. Reads return 0 unless mem_read is high. With mem_write high, operand register B is written to the addressed word at the clock edge.
- R4: The ALU first operand is the PC when alu_src_a is 0 and operand register A when it is 1. The second operand follows alu_src_b: 00 gives B, 01 gives 4, 10 gives sign-extended IR[15:0], and 11 gives that value shifted left by two.
- R5: On every clock edge the ALU output register captures the live ALU result. In the decode step (alu_src_a 0, alu_src_b 11, add) it therefore holds the incremented PC plus the scaled offset, which is the branch target.
- R6: alu_op 00 and 11 add, and 01 subtracts. 10 decodes funct: 0x20 add, 0x22 subtract, 0x24 and, 0x25 or, 0x2A signed set-less-than (result 1 or 0). Any other funct gives a result of 0.
- R7: zero is high exactly when the live ALU result is 0. overflow is high exactly when the operation is an add or subtract and its two's-complement result overflows.
- R8: Operand registers A and B capture the register-file entries named by IR[25:21] and IR[20:16] on every edge. The memory data register captures the memory read data on every edge. With reg_write high, the entry IR[15:11] (reg_dst 1) or IR[20:16] (reg_dst 0) is written with ALUOut (mem_to_reg 0) or the memory data register (mem_to_reg 1).
- R9: Register 0 always reads as 0, and writes to it are ignored.
- R10: The PC is written when pc_write is high, or when pc_write_cond is high and zero is high. Otherwise it holds.
- R11: pc_source 00 loads the live ALU result into the PC, 01 loads ALUOut, 10 loads the jump target {PC[31:28], IR[25:0], 00}, and 11 holds the PC.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pc_write | input | 1 | Unconditional PC write enable |
| pc_write_cond | input | 1 | PC write enable qualified by the zero flag |
| i_or_d | input | 1 | Memory address select: 0 PC, 1 ALUOut |
| mem_read | input | 1 | Memory read enable |
| mem_write | input | 1 | Memory write enable, data from B |
| mem_to_reg | input | 1 | Register write data: 0 ALUOut, 1 memory data register |
| ir_write | input | 1 | Instruction register load enable |
| reg_dst | input | 1 | Register write address: 0 IR[20:16], 1 IR[15:11] |
| reg_write | input | 1 | Register file write enable |
| alu_src_a | input | 1 | ALU first operand: 0 PC, 1 A |
| alu_src_b | input | 2 | ALU second operand select |
| alu_op | input | 2 | ALU operation class |
| pc_source | input | 2 | PC next-value select |
| opcode | output | 6 | IR[31:26] to the controller |
| funct | output | 6 | IR[5:0] to the controller |
| zero | output | 1 | Live ALU result equals 0 |
| overflow | output | 1 | Signed overflow of a live add or subtract |
| pc_o | output | 32 | Current PC |
| alu_out_o | output | 32 | ALU output register |

## Verification
The hardest state to reach from the ports is a PC whose top four bits are nonzero. Without it, the jump check cannot show that the target keeps the upper PC bits, and a normal fetch never produces such a PC. The bench gets there by loading 0xF0000080 into a register and then driving a cycle that passes register A through the ALU into the PC with pc_source 00. It then runs a jump. The bench acts as the controller, stepping each instruction class through its own sequence of control words. A register value is only visible after a later register-to-register operation has routed it into ALUOut, so loads, stores and writes to register 0 are checked that way. Both overflow cases are placed next to random operand mixes.

// File: rtl/mcdp_pkg.sv
`timescale 1ns/1ps
package mcdp_pkg;

    localparam int XLEN = 32;

    // ALU operation class driven by the controller
    localparam logic [1:0] OPC_ADD   = 2'b00;
    localparam logic [1:0] OPC_SUB   = 2'b01;
    localparam logic [1:0] OPC_FUNCT = 2'b10;

    // second operand selects
    localparam logic [1:0] SRCB_REG    = 2'b00;
    localparam logic [1:0] SRCB_FOUR   = 2'b01;
    localparam logic [1:0] SRCB_IMM    = 2'b10;
    localparam logic [1:0] SRCB_IMM_SH = 2'b11;

    // PC next-value selects
    localparam logic [1:0] PCS_ALU    = 2'b00;
    localparam logic [1:0] PCS_ALUOUT = 2'b01;
    localparam logic [1:0] PCS_JUMP   = 2'b10;

    // function field codes
    localparam logic [5:0] FN_CODE_ADD = 6'h20;
    localparam logic [5:0] FN_CODE_SUB = 6'h22;
    localparam logic [5:0] FN_CODE_AND = 6'h24;
    localparam logic [5:0] FN_CODE_OR  = 6'h25;
    localparam logic [5:0] FN_CODE_SLT = 6'h2A;

    typedef enum logic [2:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_AND,
        ALU_OR,
        ALU_SLT,
        ALU_NONE
    } alu_fn_e;

endpackage

// File: rtl/mcdp_alu.sv
`timescale 1ns/1ps
module mcdp_alu
    import mcdp_pkg::*;
(
    input  logic [XLEN-1:0] op_a,
    input  logic [XLEN-1:0] op_b,
    input  logic [1:0]      alu_op,
    input  logic [5:0]      funct,
    output logic [XLEN-1:0] result,
    output logic            zero,
    output logic            overflow
);

    alu_fn_e         fn;
    logic [XLEN-1:0] sum;
    logic [XLEN-1:0] diff;
    logic            ovf_add;
    logic            ovf_sub;
    logic            lt;

    always_comb begin
        unique case (alu_op)
            OPC_ADD:   fn = ALU_ADD;
            OPC_SUB:   fn = ALU_SUB;
            OPC_FUNCT: begin
                case (funct)
                    FN_CODE_ADD: fn = ALU_ADD;
                    FN_CODE_SUB: fn = ALU_SUB;
                    FN_CODE_AND: fn = ALU_AND;
                    FN_CODE_OR:  fn = ALU_OR;
                    FN_CODE_SLT: fn = ALU_SLT;
                    default:     fn = ALU_NONE;
                endcase
            end
            default:   fn = ALU_ADD;
        endcase
    end

    assign sum     = op_a + op_b;
    assign diff    = op_a - op_b;
    assign ovf_add = (op_a[XLEN-1] == op_b[XLEN-1]) && (sum[XLEN-1]  != op_a[XLEN-1]);
    assign ovf_sub = (op_a[XLEN-1] != op_b[XLEN-1]) && (diff[XLEN-1] != op_a[XLEN-1]);
    assign lt      = $signed(op_a) < $signed(op_b);

    always_comb begin
        unique case (fn)
            ALU_ADD: begin result = sum;                      overflow = ovf_add; end
            ALU_SUB: begin result = diff;                     overflow = ovf_sub; end
            ALU_AND: begin result = op_a & op_b;              overflow = 1'b0;    end
            ALU_OR:  begin result = op_a | op_b;              overflow = 1'b0;    end
            ALU_SLT: begin result = {{(XLEN-1){1'b0}}, lt};   overflow = 1'b0;    end
            default: begin result = '0;                       overflow = 1'b0;    end
        endcase
    end

    assign zero = (result == '0);

endmodule

// File: rtl/mcdp_regfile.sv
`timescale 1ns/1ps
module mcdp_regfile #(
    parameter int XLEN  = 32,
    parameter int DEPTH = 32,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   ra1,
    input  logic [AW-1:0]   ra2,
    output logic [XLEN-1:0] rd1,
    output logic [XLEN-1:0] rd2,
    input  logic            we,
    input  logic [AW-1:0]   wa,
    input  logic [XLEN-1:0] wd
);

    logic [XLEN-1:0] regs_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) regs_q[i] <= '0;
        end else if (we && (wa != '0)) begin
            regs_q[wa] <= wd;
        end
    end

    // entry zero is never written, and the read port forces it as well
    assign rd1 = (ra1 == '0) ? '0 : regs_q[ra1];
    assign rd2 = (ra2 == '0) ? '0 : regs_q[ra2];

endmodule

// File: rtl/mcdp_mem.sv
`timescale 1ns/1ps
module mcdp_mem #(
    parameter int XLEN  = 32,
    parameter int WORDS = 256,
    parameter int AW    = $clog2(WORDS)
) (
    input  logic            clk,
    input  logic [AW-1:0]   idx,
    input  logic            re,
    input  logic            we,
    input  logic [XLEN-1:0] wdata,
    output logic [XLEN-1:0] rdata
);

    logic [XLEN-1:0] mem_q [WORDS];

    always_ff @(posedge clk) begin
        if (we) mem_q[idx] <= wdata;
    end

    assign rdata = re ? mem_q[idx] : '0;

endmodule

// File: rtl/mcdp_core.sv
`timescale 1ns/1ps
module mcdp_core
    import mcdp_pkg::*;
#(
    parameter int REG_COUNT = 32,
    parameter int MEM_WORDS = 256
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pc_write,
    input  logic        pc_write_cond,
    input  logic        i_or_d,
    input  logic        mem_read,
    input  logic        mem_write,
    input  logic        mem_to_reg,
    input  logic        ir_write,
    input  logic        reg_dst,
    input  logic        reg_write,
    input  logic        alu_src_a,
    input  logic [1:0]  alu_src_b,
    input  logic [1:0]  alu_op,
    input  logic [1:0]  pc_source,
    output logic [5:0]  opcode,
    output logic [5:0]  funct,
    output logic        zero,
    output logic        overflow,
    output logic [31:0] pc_o,
    output logic [31:0] alu_out_o
);

    localparam int RAW = $clog2(REG_COUNT);
    localparam int MAW = $clog2(MEM_WORDS);

    logic [XLEN-1:0] pc_q, ir_q, mdr_q, a_q, b_q, alu_out_q;
    logic [XLEN-1:0] mem_rdata, rf_rd1, rf_rd2, wr_data;
    logic [XLEN-1:0] imm_sx, src_a, src_b, alu_res, jump_tgt, pc_next;
    logic [MAW-1:0]  mem_idx;
    logic [RAW-1:0]  wr_addr;
    logic            pc_en;

    // memory address: fetch from PC or access data at ALUOut
    assign mem_idx = i_or_d ? alu_out_q[MAW+1:2] : pc_q[MAW+1:2];

    mcdp_mem #(.XLEN(XLEN), .WORDS(MEM_WORDS), .AW(MAW)) u_mem (
        .clk   (clk),
        .idx   (mem_idx),
        .re    (mem_read),
        .we    (mem_write),
        .wdata (b_q),
        .rdata (mem_rdata)
    );

    assign wr_addr = reg_dst    ? ir_q[11 +: RAW] : ir_q[16 +: RAW];
    assign wr_data = mem_to_reg ? mdr_q           : alu_out_q;

    mcdp_regfile #(.XLEN(XLEN), .DEPTH(REG_COUNT), .AW(RAW)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .ra1   (ir_q[21 +: RAW]),
        .ra2   (ir_q[16 +: RAW]),
        .rd1   (rf_rd1),
        .rd2   (rf_rd2),
        .we    (reg_write),
        .wa    (wr_addr),
        .wd    (wr_data)
    );

    assign imm_sx = {{(XLEN-16){ir_q[15]}}, ir_q[15:0]};
    assign src_a  = alu_src_a ? a_q : pc_q;

    always_comb begin
        unique case (alu_src_b)
            SRCB_REG:    src_b = b_q;
            SRCB_FOUR:   src_b = XLEN'(4);
            SRCB_IMM:    src_b = imm_sx;
            SRCB_IMM_SH: src_b = {imm_sx[XLEN-3:0], 2'b00};
            default:     src_b = b_q;
        endcase
    end

    mcdp_alu u_alu (
        .op_a     (src_a),
        .op_b     (src_b),
        .alu_op   (alu_op),
        .funct    (ir_q[5:0]),
        .result   (alu_res),
        .zero     (zero),
        .overflow (overflow)
    );

    assign jump_tgt = {pc_q[31:28], ir_q[25:0], 2'b00};
    assign pc_en    = pc_write | (pc_write_cond & zero);

    always_comb begin
        unique case (pc_source)
            PCS_ALU:    pc_next = alu_res;
            PCS_ALUOUT: pc_next = alu_out_q;
            PCS_JUMP:   pc_next = jump_tgt;
            default:    pc_next = pc_q;
        endcase
    end

    // program counter and instruction register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q <= '0;
            ir_q <= '0;
        end else begin
            if (pc_en)    pc_q <= pc_next;
            if (ir_write) ir_q <= mem_rdata;
        end
    end

    // holding registers written on every cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mdr_q     <= '0;
            a_q       <= '0;
            b_q       <= '0;
            alu_out_q <= '0;
        end else begin
            mdr_q     <= mem_rdata;
            a_q       <= rf_rd1;
            b_q       <= rf_rd2;
            alu_out_q <= alu_res;
        end
    end

    assign opcode    = ir_q[31:26];
    assign funct     = ir_q[5:0];
    assign pc_o      = pc_q;
    assign alu_out_o = alu_out_q;

endmodule

// File: rtl/mcdp_core_chk.sv
`timescale 1ns/1ps
module mcdp_core_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        pc_write,
    input logic        pc_write_cond,
    input logic        ir_write,
    input logic        alu_src_a,
    input logic [1:0]  alu_src_b,
    input logic [1:0]  alu_op,
    input logic [1:0]  pc_source,
    input logic [5:0]  opcode,
    input logic [5:0]  funct,
    input logic        zero,
    input logic        overflow,
    input logic [31:0] pc_o,
    input logic [31:0] ir_q,
    input logic [31:0] rf_rd1
);

    a_r10_pc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!pc_write && !pc_write_cond) |=> $stable(pc_o));

    a_r10_cond_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (!pc_write && pc_write_cond && !zero) |=> $stable(pc_o));

    a_r2_ir_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ir_write |=> ($stable(opcode) && $stable(funct)));

    a_r11_jump_target: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_write && pc_source == 2'b10) |=>
            (pc_o == {$past(pc_o[31:28]), $past(ir_q[25:0]), 2'b00}));

    a_r4_pc_increment: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_write && pc_source == 2'b00 && !alu_src_a && alu_src_b == 2'b01 && alu_op == 2'b00)
            |=> (pc_o == $past(pc_o) + 32'd4));

    a_r7_overflow_scope: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> (alu_op != 2'b10 || funct == 6'h20 || funct == 6'h22));

    a_r9_zero_reg: assert property (@(posedge clk) disable iff (!rst_n)
        (ir_q[25:21] == 5'd0) |-> (rf_rd1 == 32'd0));

endmodule

bind mcdp_core mcdp_core_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .pc_write      (pc_write),
    .pc_write_cond (pc_write_cond),
    .ir_write      (ir_write),
    .alu_src_a     (alu_src_a),
    .alu_src_b     (alu_src_b),
    .alu_op        (alu_op),
    .pc_source     (pc_source),
    .opcode        (opcode),
    .funct         (funct),
    .zero          (zero),
    .overflow      (overflow),
    .pc_o          (pc_o),
    .ir_q          (ir_q),
    .rf_rd1        (rf_rd1)
);

// File: tb/mcdp_core_tb.sv
`timescale 1ns/1ps
module mcdp_core_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        pc_write, pc_write_cond, i_or_d, mem_read, mem_write;
    logic        mem_to_reg, ir_write, reg_dst, reg_write, alu_src_a;
    logic [1:0]  alu_src_b, alu_op, pc_source;
    logic [5:0]  opcode, funct;
    logic        zero, overflow;
    logic [31:0] pc_o, alu_out_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    logic [31:0] ref_regs [32];
    logic [31:0] ref_dmem [256];
    logic [31:0] pc_m;
    logic [31:0] sample_seed;

    mcdp_core u_dut (
        .clk(clk), .rst_n(rst_n), .pc_write(pc_write), .pc_write_cond(pc_write_cond),
        .i_or_d(i_or_d), .mem_read(mem_read), .mem_write(mem_write),
        .mem_to_reg(mem_to_reg), .ir_write(ir_write), .reg_dst(reg_dst),
        .reg_write(reg_write), .alu_src_a(alu_src_a), .alu_src_b(alu_src_b),
        .alu_op(alu_op), .pc_source(pc_source), .opcode(opcode), .funct(funct),
        .zero(zero), .overflow(overflow), .pc_o(pc_o), .alu_out_o(alu_out_o)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 50000 && !done) begin
            checks = checks + 1;
            fails  = fails + 1;
            $display("FAIL watchdog actual=%0d expected=finish", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        pc_write = 0; pc_write_cond = 0; i_or_d = 0; mem_read = 0; mem_write = 0;
        mem_to_reg = 0; ir_write = 0; reg_dst = 0; reg_write = 0; alu_src_a = 0;
        alu_src_b = 2'b00; alu_op = 2'b00; pc_source = 2'b00;
    endtask

    function automatic logic [31:0] sx(input logic [15:0] v);
        return {{16{v[15]}}, v};
    endfunction

    function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input logic [5:0] fn);
        return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction

    function automatic logic [31:0] ref_alu(input logic [5:0] fn, input logic [31:0] a, input logic [31:0] b);
        case (fn)
            6'h20:   return a + b;
            6'h22:   return a - b;
            6'h24:   return a & b;
            6'h25:   return a | b;
            6'h2A:   return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            default: return 32'd0;
        endcase
    endfunction

    function automatic logic ref_ovf(input logic [5:0] fn, input logic [31:0] a, input logic [31:0] b);
        logic [31:0] s;
        if (fn == 6'h20) begin s = a + b; return (a[31] == b[31]) && (s[31] != a[31]); end
        if (fn == 6'h22) begin s = a - b; return (a[31] != b[31]) && (s[31] != a[31]); end
        return 1'b0;
    endfunction

    task automatic set_data(input logic [31:0] addr, input logic [31:0] val);
        ref_dmem[addr[9:2]] = val;
        u_dut.u_mem.mem_q[addr[9:2]] = val;
    endtask

    // fetch and decode steps common to every instruction class
    task automatic fetch_decode(input logic [31:0] word);
        u_dut.u_mem.mem_q[pc_m[9:2]] = word;
        idle(); mem_read = 1; ir_write = 1; alu_src_b = 2'b01; pc_write = 1;
        tick();
        pc_m = pc_m + 4;
        chk("R4 fetch pc+4", pc_o, pc_m);
        chk("R2 opcode", {26'd0, opcode}, {26'd0, word[31:26]});
        chk("R2 funct", {26'd0, funct}, {26'd0, word[5:0]});
        idle(); alu_src_b = 2'b11;
        tick();
        chk("R5 branch target", alu_out_o, pc_m + {sx(word[15:0])[29:0], 2'b00});
    endtask

    task automatic do_rtype(input logic [5:0] fn, input int rs, input int rt, input int rd, input string req);
        logic [31:0] e;
        e = ref_alu(fn, ref_regs[rs], ref_regs[rt]);
        fetch_decode(enc_r(rs, rt, rd, fn));
        idle(); alu_src_a = 1; alu_op = 2'b10;
        #1;
        chk({"R7 overflow ", req}, {31'd0, overflow}, {31'd0, ref_ovf(fn, ref_regs[rs], ref_regs[rt])});
        chk({"R7 zero ", req}, {31'd0, zero}, {31'd0, (e == 32'd0)});
        @(negedge clk);
        chk({"R6 result ", req}, alu_out_o, e);
        idle(); reg_dst = 1; reg_write = 1;
        tick();
        if (rd != 0) ref_regs[rd] = e;
        idle();
    endtask

    task automatic do_lw(input int rt, input int base, input logic [15:0] imm);
        logic [31:0] addr;
        addr = ref_regs[base] + sx(imm);
        fetch_decode(enc_i(6'h23, base, rt, imm));
        idle(); alu_src_a = 1; alu_src_b = 2'b10;
        tick();
        idle(); i_or_d = 1; mem_read = 1;
        tick();
        idle(); mem_to_reg = 1; reg_write = 1;
        tick();
        if (rt != 0) ref_regs[rt] = ref_dmem[addr[9:2]];
        idle();
    endtask

    task automatic do_sw(input int rt, input int base, input logic [15:0] imm);
        logic [31:0] addr;
        addr = ref_regs[base] + sx(imm);
        fetch_decode(enc_i(6'h2B, base, rt, imm));
        idle(); alu_src_a = 1; alu_src_b = 2'b10;
        tick();
        chk("R3 store address", alu_out_o, addr);
        idle(); i_or_d = 1; mem_write = 1;
        tick();
        ref_dmem[addr[9:2]] = ref_regs[rt];
        idle();
    endtask

    task automatic do_beq(input int rs, input int rt, input logic [15:0] off, input string req);
        logic [31:0] tgt;
        logic        taken;
        taken = (ref_regs[rs] == ref_regs[rt]);
        fetch_decode(enc_i(6'h04, rs, rt, off));
        tgt = pc_m + {sx(off)[29:0], 2'b00};
        idle(); alu_src_a = 1; alu_op = 2'b01; pc_write_cond = 1; pc_source = 2'b01;
        #1;
        chk({"R7 compare zero ", req}, {31'd0, zero}, {31'd0, taken});
        @(negedge clk);
        if (taken) pc_m = tgt;
        chk({"R10 branch pc ", req}, pc_o, pc_m);
        idle();
    endtask

    task automatic do_j(input logic [25:0] t);
        fetch_decode({6'h02, t});
        idle(); pc_write = 1; pc_source = 2'b10;
        tick();
        pc_m = {pc_m[31:28], t, 2'b00};
        chk("R11 jump target", pc_o, pc_m);
        idle();
    endtask

    // pass register rs through the ALU straight into the PC
    task automatic pc_from_reg(input int rs);
        fetch_decode(enc_r(rs, 0, 0, 6'h20));
        idle(); alu_src_a = 1; pc_write = 1; pc_source = 2'b00;
        tick();
        pc_m = ref_regs[rs];
        chk("R11 live result to pc", pc_o, pc_m);
        idle();
    endtask

    initial begin
        logic [31:0] v;
        logic [5:0]  fns [5];
        logic [31:0] w_held;
        fns[0] = 6'h20; fns[1] = 6'h22; fns[2] = 6'h24; fns[3] = 6'h25; fns[4] = 6'h2A;
        sample_seed = $urandom(32'd20240611);
        for (int i = 0; i < 32; i++) ref_regs[i] = 32'd0;
        for (int i = 0; i < 256; i++) ref_dmem[i] = 32'd0;
        pc_m = 32'd0;
        idle();
        rst_n = 1'b0;
        for (int i = 0; i < 256; i++) u_dut.u_mem.mem_q[i] = 32'd0;
        tick(); tick(); tick();
        chk("R1 pc reset", pc_o, 32'd0);
        chk("R1 aluout reset", alu_out_o, 32'd0);
        chk("R1 opcode reset", {26'd0, opcode}, 32'd0);
        chk("R1 funct reset", {26'd0, funct}, 32'd0);
        rst_n = 1'b1;
        tick();

        // load every register through the data path, R8 with reg_dst 0
        for (int r = 1; r < 32; r++) begin
            case (r)
                1:       v = 32'h7FFF_FFFF;
                2:       v = 32'h0000_0001;
                3:       v = 32'h8000_0000;
                4:       v = 32'hFFFF_FFFF;
                10:      v = 32'd900;
                13:      v = 32'hF000_0080;
                default: v = $urandom;
            endcase
            set_data(32'd768 + 32'(4 * (r - 1)), v);
            do_lw(r, 0, 16'(768 + 4 * (r - 1)));
        end

        do_rtype(6'h20, 1, 2, 5, "add overflow");
        do_rtype(6'h22, 3, 2, 6, "sub overflow");
        do_rtype(6'h2A, 3, 2, 7, "slt signed true");
        do_rtype(6'h2A, 2, 3, 7, "slt signed false");
        do_rtype(6'h20, 4, 2, 8, "add to zero");
        do_rtype(6'h27, 1, 2, 9, "undefined funct");
        do_rtype(6'h24, 4, 13, 14, "and");
        do_rtype(6'h25, 3, 2, 15, "or");

        // R9: writes to register 0 are dropped
        do_rtype(6'h20, 1, 1, 0, "write r0");
        do_rtype(6'h25, 0, 0, 9, "R9 read r0 after rtype");
        do_lw(0, 0, 16'd768);
        do_rtype(6'h25, 0, 0, 9, "R9 read r0 after load");

        // R3 store then reload with a negative offset
        do_sw(4, 10, 16'hFFFC);
        do_lw(11, 10, 16'hFFFC);
        do_rtype(6'h25, 11, 0, 12, "R3 R8 reload of stored word");

        // R2 instruction register hold with different memory contents
        w_held = enc_r(1, 2, 16, 6'h22);
        fetch_decode(w_held);
        u_dut.u_mem.mem_q[pc_m[9:2]] = enc_i(6'h23, 0, 0, 16'h0);
        idle(); mem_read = 1;
        tick();
        chk("R2 ir held opcode", {26'd0, opcode}, {26'd0, w_held[31:26]});
        chk("R2 ir held funct", {26'd0, funct}, {26'd0, w_held[5:0]});
        chk("R10 pc held", pc_o, pc_m);

        do_beq(2, 2, 16'd3, "taken forward");
        do_beq(1, 2, 16'd5, "not taken");
        do_beq(4, 4, 16'hFFFE, "taken backward");
        do_j(26'h000_0040);
        pc_from_reg(13);
        do_j(26'h000_0050);

        for (int k = 0; k < 40; k++) begin
            do_rtype(fns[$urandom_range(0, 4)], $urandom_range(0, 31),
                     $urandom_range(0, 31), $urandom_range(0, 31), "R6 random");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule